// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in-first-out buffer whose write side and read side run on two clocks with no fixed relationship. Either clock may be slow, fast or stopped. Words enter on the write clock when the write enable is high and leave on the read clock when the read enable is high. The block raises five status flags: empty, full, half-full, almost-empty and almost-full.

The almost-empty flag compares the fill level against one offset, measured up from an empty buffer. The almost-full flag compares it against a second offset, measured down from a full buffer. Both offsets come from one of eight presets. A 3-bit code on pins selects the preset during master reset. Software-free bit-serial loading on the write clock can replace the offsets later. A partial reset empties the buffer and keeps the offsets. A master reset empties the buffer and returns the offsets to the preset.

Read and write pointers cross between the clock domains in Gray code through two-flop synchronisers. The offsets are quasi-static: change them only while no traffic is flowing.

Top module: `prog_flag_fifo`

## Requirements
- R1: After master reset the flags read empty=1, full=0, half_full=0, almost_empty=1 and almost_full=0.
- R2: Words leave the read port in the order they were written, with no loss and no duplication. `rd_data` is registered and updates on the read-clock edge that accepts the read.
- R3: A write while `full` is high is ignored. The stored words and the write pointer are unchanged, so the extra word is never read back.
- R4: A read while `empty` is high is ignored. `rd_data` holds its value, and the next word written is the next word read.
- R5: `full` is high when 2^AW words are held (4096 by default). `empty` is high when no word is held.
- R6: `half_full` is high when the fill level is greater than 2^AW/2. At 2048 words it is low; at 2049 words it is high.
- R7: `almost_empty` is high when the fill level is less than or equal to the almost-empty offset.
- R8: `almost_full` is high when the fill level is greater than or equal to 2^AW minus the almost-full offset.
- R9: Both offsets load on every write-clock edge while `mrst_n` is low. The loaded value is 2^(code+3)-1, where code = {thr_load, thr_sel[1], thr_sel[0]}. This gives 7, 15, 31, 63, 127, 255, 511 or 1023.
- R10: On a write-clock edge with `mrst_n` high and both `ser_en` and `thr_load` high, one bit of `ser_din` is stored. The first AW bits fill the almost-empty offset, least significant bit first. The next AW bits fill the almost-full offset, least significant bit first. Further bits wrap around to the almost-empty offset.
- R11: A partial reset (`prst_n` low) empties the buffer, so `empty`=1 and `almost_empty`=1. The offsets in force before it stay in force.
- R12: With `flag_mode`=0, `almost_empty` comes from the read-domain evaluation and `almost_full` from the write-domain evaluation. With `flag_mode`=1, each almost flag is the OR of its read-domain and write-domain evaluations, so it updates on both clocks. Once the pointers have crossed, both modes give the same values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low: clears the buffer and reloads the offset presets |
| prst_n | input | 1 | Partial reset, active low: clears the buffer and keeps the offsets |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read enable |
| rd_data | output | DW | Registered read data |
| thr_load | input | 1 | Preset code MSB during master reset; serial load qualifier afterwards |
| thr_sel | input | 2 | Lower preset code bits |
| ser_en | input | 1 | Serial offset load enable |
| ser_din | input | 1 | Serial offset data bit |
| flag_mode | input | 1 | Almost-flag timing mode |
| empty | output | 1 | No word held |
| full | output | 1 | 2^AW words held |
| half_full | output | 1 | More than half the depth held |
| almost_empty | output | 1 | Fill level at or below the almost-empty offset |
| almost_full | output | 1 | Fill level at or above depth minus the almost-full offset |

## Verification
The assertions check several properties on every cycle:
- a blocked write never moves the write pointer, and a blocked read never moves the read pointer or changes the output data;
- full always implies half-full and almost-full;
- empty always implies almost-empty;
- the reset preset lands in the offset registers;
- each qualified serial bit advances the load position.

Only the bench scenarios can show the exact fill levels where each flag flips, under both presets and under serial offsets. The same applies to the end-to-end data order across a full buffer, the bit order and wrap-around of the serial stream, and the retention of offsets through a partial reset. The agreement between the two flag modes is also shown only by the scenarios.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    // Offset preset selected by a 3-bit code: 2^(code+3) - 1
    function automatic logic [31:0] preset_offset(input logic [2:0] code);
        return (32'd1 << ({2'b00, code} + 5'd3)) - 32'd1;
    endfunction

endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/pfifo_offset_load.sv
module pfifo_offset_load #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic [2:0]    code,
    input  logic          ser_en,
    input  logic          ser_qual,
    input  logic          ser_din,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);
    import pfifo_pkg::*;

    localparam int NBITS = 2 * AW;
    localparam int IW    = $clog2(NBITS);

    typedef struct packed {
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
        logic [IW-1:0] idx;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (!mrst_n) begin
            ld_d.ae  = AW'(preset_offset(code));
            ld_d.af  = AW'(preset_offset(code));
            ld_d.idx = '0;
        end else if (ser_en && ser_qual) begin
            for (int i = 0; i < AW; i++) begin
                if (ld_q.idx == IW'(i))      ld_d.ae[i] = ser_din;
                if (ld_q.idx == IW'(i + AW)) ld_d.af[i] = ser_din;
            end
            ld_d.idx = (ld_q.idx == IW'(NBITS - 1)) ? '0 : ld_q.idx + IW'(1);
        end
    end

    // Synchronous master load: the offsets take the pin-selected preset each edge in reset
    always_ff @(posedge clk) begin
        ld_q <= ld_d;
    end

    assign ae_off = ld_q.ae;
    assign af_off = ld_q.af;

    // R9: the first cycle out of master reset shows the preset chosen at the last reset edge
    a_r9_preset_after_reset: assert property (@(posedge clk) disable iff (!mrst_n)
        $rose(mrst_n) |-> (ld_q.ae == AW'(preset_offset($past(code)))) &&
                          (ld_q.af == AW'(preset_offset($past(code)))));

    // R10: each qualified serial bit advances the load position by one
    a_r10_idx_advance: assert property (@(posedge clk) disable iff (!mrst_n)
        (ser_en && ser_qual && ld_q.idx != IW'(NBITS - 1)) |=> ld_q.idx == $past(ld_q.idx) + IW'(1));
endmodule

// File: rtl/pfifo_wr_side.sv
module pfifo_wr_side #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [AW:0]   rgray_sync,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          hf,
    output logic          af,
    output logic          ae
);
    localparam int          DEPTH   = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        full;
        logic        hf;
        logic        af;
        logic        ae;
    } wst_t;

    wst_t w_d, w_q;
    logic [AW:0] nbin, rbin, cnt;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    always_comb begin
        push       = wen && !w_q.full;
        nbin       = w_q.bin + (AW+1)'(push);
        rbin       = g2b(rgray_sync);
        cnt        = nbin - rbin;
        w_d.bin    = nbin;
        w_d.gray   = nbin ^ (nbin >> 1);
        w_d.full   = w_d.gray == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};
        w_d.hf     = cnt > HALF_V;
        w_d.af     = cnt >= (DEPTH_V - {1'b0, af_off});
        w_d.ae     = cnt <= {1'b0, ae_off};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{bin: '0, gray: '0, full: 1'b0, hf: 1'b0, af: 1'b0, ae: 1'b1};
        else        w_q <= w_d;
    end

    assign waddr = w_q.bin[AW-1:0];
    assign wgray = w_q.gray;
    assign full  = w_q.full;
    assign hf    = w_q.hf;
    assign af    = w_q.af;
    assign ae    = w_q.ae;

    // R3: a write attempt while full leaves the write pointer where it was
    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.full && wen) |=> $stable(w_q.bin));

    // R6: a full buffer is also beyond half
    a_r6_hf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.full |-> w_q.hf);

    // R8: a full buffer is also almost full
    a_r8_af_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.full |-> w_q.af);
endmodule

// File: rtl/pfifo_rd_side.sv
module pfifo_rd_side #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    output logic          pop,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          ae,
    output logic          af
);
    localparam int          DEPTH   = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        empty;
        logic        ae;
        logic        af;
    } rst_t;

    rst_t r_d, r_q;
    logic [AW:0] nbin, wbin, cnt;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    always_comb begin
        pop       = ren && !r_q.empty;
        nbin      = r_q.bin + (AW+1)'(pop);
        wbin      = g2b(wgray_sync);
        cnt       = wbin - nbin;
        r_d.bin   = nbin;
        r_d.gray  = nbin ^ (nbin >> 1);
        r_d.empty = r_d.gray == wgray_sync;
        r_d.ae    = cnt <= {1'b0, ae_off};
        r_d.af    = cnt >= (DEPTH_V - {1'b0, af_off});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{bin: '0, gray: '0, empty: 1'b1, ae: 1'b1, af: 1'b0};
        else        r_q <= r_d;
    end

    assign raddr = r_q.bin[AW-1:0];
    assign rgray = r_q.gray;
    assign empty = r_q.empty;
    assign ae    = r_q.ae;
    assign af    = r_q.af;

    // R4: a read attempt while empty leaves the read pointer where it was
    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.empty && ren) |=> $stable(r_q.bin));

    // R7: an empty buffer is also almost empty
    a_r7_ae_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.empty |-> r_q.ae);
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          thr_load,
    input  logic [1:0]    thr_sel,
    input  logic          ser_en,
    input  logic          ser_din,
    input  logic          flag_mode,
    output logic          empty,
    output logic          full,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int DEPTH = 1 << AW;

    logic          ptr_rst_n;
    logic [AW-1:0] ae_off, af_off;
    logic          w_push, r_pop;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_rs, rgray_ws;
    logic          ae_r, af_r, ae_w, af_w;
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdat_d, rdat_q;

    assign ptr_rst_n = mrst_n & prst_n;

    pfifo_offset_load #(.AW(AW)) u_offs (
        .clk(wr_clk), .mrst_n(mrst_n), .code({thr_load, thr_sel}),
        .ser_en(ser_en), .ser_qual(thr_load), .ser_din(ser_din),
        .ae_off(ae_off), .af_off(af_off)
    );

    pfifo_wr_side #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(ptr_rst_n), .wen(wr_en), .rgray_sync(rgray_ws),
        .ae_off(ae_off), .af_off(af_off), .push(w_push), .waddr(waddr),
        .wgray(wgray), .full(full), .hf(half_full), .af(af_w), .ae(ae_w)
    );

    pfifo_rd_side #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(ptr_rst_n), .ren(rd_en), .wgray_sync(wgray_rs),
        .ae_off(ae_off), .af_off(af_off), .pop(r_pop), .raddr(raddr),
        .rgray(rgray), .empty(empty), .ae(ae_r), .af(af_r)
    );

    pfifo_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(ptr_rst_n), .d(wgray), .q(wgray_rs));
    pfifo_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(ptr_rst_n), .d(rgray), .q(rgray_ws));

    always_ff @(posedge wr_clk) begin
        if (w_push) mem[waddr] <= wr_data;
    end

    always_comb begin
        rdat_d = r_pop ? mem[raddr] : rdat_q;
    end

    always_ff @(posedge rd_clk or negedge ptr_rst_n) begin
        if (!ptr_rst_n) rdat_q <= '0;
        else            rdat_q <= rdat_d;
    end

    assign rd_data      = rdat_q;
    assign almost_empty = flag_mode ? (ae_r | ae_w) : ae_r;
    assign almost_full  = flag_mode ? (af_w | af_r) : af_w;

    // R4: a read attempt on an empty buffer leaves the output word untouched
    a_r4_rdata_hold: assert property (@(posedge rd_clk) disable iff (!ptr_rst_n)
        (rd_en && empty) |=> $stable(rd_data));
endmodule

// File: tb/tb_prog_flag_fifo.sv
module tb_prog_flag_fifo;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic thr_load = 1'b0, ser_en = 1'b0, ser_din = 1'b0, flag_mode = 1'b0;
    logic [1:0] thr_sel = 2'b00;
    logic empty, full, half_full, almost_empty, almost_full;

    int n_chk = 0, n_fail = 0;
    int wseq = 0, rseq = 0;

    always #2 wr_clk = ~wr_clk;
    always #3 rd_clk = ~rd_clk;

    prog_flag_fifo #(.DW(DW), .AW(AW)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .thr_load(thr_load), .thr_sel(thr_sel), .ser_en(ser_en), .ser_din(ser_din),
        .flag_mode(flag_mode), .empty(empty), .full(full), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic flag(input logic v, input logic e, input string what);
        check(v === e, what, int'(v), int'(e));
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (2) @(negedge wr_clk);
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            wr_data = wseq[DW-1:0];
            wseq++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        settle();
    endtask

    task automatic write_junk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            wr_data = 16'hDEAD;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        settle();
    endtask

    task automatic read_n(input int n, output int errs);
        errs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_en = 1'b1;
            @(negedge rd_clk);
            rd_en = 1'b0;
            if (rd_data !== rseq[DW-1:0]) errs++;
            rseq++;
        end
        settle();
    endtask

    task automatic part_reset();
        @(negedge wr_clk);
        prst_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        @(negedge wr_clk);
        prst_n = 1'b1;
        rseq = wseq;
        settle();
    endtask

    task automatic master_reset(input logic [2:0] code);
        @(negedge wr_clk);
        mrst_n = 1'b0;
        {thr_load, thr_sel} = code;
        repeat (4) @(negedge wr_clk);
        repeat (2) @(negedge rd_clk);
        @(negedge wr_clk);
        mrst_n = 1'b1;
        thr_load = 1'b0;
        rseq = wseq;
        settle();
    endtask

    task automatic ser_load(input logic [AW-1:0] v);
        for (int i = 0; i < AW; i++) begin
            @(negedge wr_clk);
            ser_en = 1'b1;
            thr_load = 1'b1;
            ser_din = v[i];
        end
        @(negedge wr_clk);
        ser_en = 1'b0;
        thr_load = 1'b0;
    endtask

    task automatic t_reset();
        flag(empty, 1'b1, "R1 empty after reset");
        flag(full, 1'b0, "R1 full after reset");
        flag(half_full, 1'b0, "R1 half_full after reset");
        flag(almost_empty, 1'b1, "R1 almost_empty after reset");
        flag(almost_full, 1'b0, "R1 almost_full after reset");
    endtask

    task automatic t_small_preset();
        int errs;
        logic [DW-1:0] held;
        write_n(7);
        flag(empty, 1'b0, "R5 empty low with 7 words");
        flag(almost_empty, 1'b1, "R7 R9 almost_empty at 7 with preset 7");
        write_n(1);
        flag(almost_empty, 1'b0, "R7 R9 almost_empty at 8 with preset 7");
        read_n(8, errs);
        check(errs == 0, "R2 order of 8 words", errs, 0);
        flag(empty, 1'b1, "R5 empty after draining");
        held = rd_data;
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
        settle();
        check(rd_data === held, "R4 rd_data held on empty read", int'(rd_data), int'(held));
        flag(empty, 1'b1, "R4 still empty after blocked read");
        write_n(1);
        read_n(1, errs);
        check(errs == 0, "R4 next word after blocked read", errs, 0);
    endtask

    task automatic t_fill();
        int errs;
        part_reset();
        write_n(DEPTH / 2);
        flag(half_full, 1'b0, "R6 half_full at exactly half");
        write_n(1);
        flag(half_full, 1'b1, "R6 half_full just above half");
        write_n(DEPTH - 8 - (DEPTH / 2 + 1));
        flag(almost_full, 1'b0, "R8 almost_full at depth-8");
        write_n(1);
        flag(almost_full, 1'b1, "R8 almost_full at depth-7");
        write_n(6);
        flag(full, 1'b0, "R5 full at depth-1");
        write_n(1);
        flag(full, 1'b1, "R5 full at depth");
        write_junk(5);
        flag(full, 1'b1, "R3 full after blocked writes");
        read_n(DEPTH, errs);
        check(errs == 0, "R2 R3 order of full buffer", errs, 0);
        flag(empty, 1'b1, "R3 empty after reading depth words");
    endtask

    task automatic t_serial();
        ser_load(AW'(100));
        ser_load(AW'(200));
        part_reset();
        write_n(100);
        flag(almost_empty, 1'b1, "R10 almost_empty at serial offset 100");
        write_n(1);
        flag(almost_empty, 1'b0, "R10 almost_empty at 101");
        part_reset();
        flag(empty, 1'b1, "R11 empty after partial reset");
        flag(almost_empty, 1'b1, "R11 almost_empty after partial reset");
        write_n(100);
        flag(almost_empty, 1'b1, "R11 offset 100 kept at 100");
        write_n(1);
        flag(almost_empty, 1'b0, "R11 offset 100 kept at 101");
        part_reset();
        write_n(DEPTH - 201);
        flag(almost_full, 1'b0, "R10 almost_full below serial offset 200");
        write_n(1);
        flag(almost_full, 1'b1, "R10 almost_full at depth-200");
    endtask

    task automatic t_wrap();
        ser_load(AW'(50));
        part_reset();
        write_n(50);
        flag(almost_empty, 1'b1, "R10 wrapped offset 50 at 50");
        write_n(1);
        flag(almost_empty, 1'b0, "R10 wrapped offset 50 at 51");
        write_n(DEPTH - 201 - 51);
        flag(almost_full, 1'b0, "R10 almost_full offset 200 kept after wrap, below");
        write_n(1);
        flag(almost_full, 1'b1, "R10 almost_full offset 200 kept after wrap, at");
    endtask

    task automatic t_big_preset();
        master_reset(3'b111);
        t_reset();
        write_n(1023);
        flag(almost_empty, 1'b1, "R9 preset 1023 almost_empty at 1023");
        write_n(1);
        flag(almost_empty, 1'b0, "R9 preset 1023 almost_empty at 1024");
        write_n(DEPTH - 1024 - 1024);
        flag(almost_full, 1'b0, "R9 preset 1023 almost_full below");
        write_n(1);
        flag(almost_full, 1'b1, "R9 preset 1023 almost_full at depth-1023");
    endtask

    task automatic t_mode();
        flag_mode = 1'b1;
        part_reset();
        flag(almost_empty, 1'b1, "R12 mode1 almost_empty when empty");
        flag(almost_full, 1'b0, "R12 mode1 almost_full when empty");
        write_n(1024);
        flag(almost_empty, 1'b0, "R12 mode1 almost_empty at 1024");
        write_n(DEPTH - 1023 - 1024);
        flag(almost_full, 1'b1, "R12 mode1 almost_full at depth-1023");
        flag(half_full, 1'b1, "R12 mode1 half_full");
        flag_mode = 1'b0;
        settle();
        flag(almost_full, 1'b1, "R12 mode0 agrees after settling");
    endtask

    initial begin
        #700000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        master_reset(3'b000);
        t_reset();
        t_small_preset();
        t_fill();
        t_serial();
        t_wrap();
        t_big_preset();
        t_mode();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule